// File: doc/BRIEF.md
# Pipelined Parity Checker with Error Hold

This block registers a data word on each clock and checks it for even parity against a parity bit that arrives one clock after the word it covers. The XOR of the word's bits and that late parity bit must be 0. When it is 1, an active-low error flag drops and stays low for a fixed number of cycles. A new mismatch during that window starts the window again. Two active-low select inputs qualify each word. A word is checked only when at least one of them was low at the edge that took it in.

A wide word can be split over two instances. The first instance folds its half of the word into the incoming parity bit and sends the result out as a registered partial parity. The second instance takes that partial parity on its parity input and delays its own data parity by one more cycle to line up with it. Only the second instance drives a meaningful error flag. A single instance can also check a whole word alone.

The reset is active low and asynchronous. It clears all held data, parity and error state at once. The mode inputs are static: they change only while reset is low.

Top module: `parity_pipe_chk`

## Requirements
- R1: While `rst_n` is low, `err_n` is 1 and `ppo` is 0. After reset is released, no stale word is checked: the first parity bit seen after reset cannot raise an error.
- R2: Single mode (`cascade_en`=0). The word taken at edge k is checked against `par_in` sampled at edge k+1. A mismatch means XOR of all word bits and `par_in` equals 1 (even parity).
- R3: In single mode, a mismatch found at edge k+1 drives `err_n` low right after that edge, so `err_n` is low two edges after the word was taken.
- R4: Once low, `err_n` stays low for HOLD cycles (default 2) and then returns to 1 if no further mismatch occurs.
- R5: A mismatch detected while `err_n` is already low restarts the HOLD-cycle window from that edge.
- R6: A word taken while `sel_a_n` and `sel_b_n` were both 1 is never checked and never causes an error. A word is checked when either select is 0, or both are.
- R7: First-instance mode (`cascade_en`=1, `stage_b`=0). `ppo` after edge k+1 equals XOR of the word taken at edge k and `par_in` at edge k+1 when that word was accepted, and 0 otherwise. `err_n` stays 1 in this mode. Single mode drives `ppo` the same way.
- R8: Second-instance mode (`cascade_en`=1, `stage_b`=1). The word taken at edge k is checked against `par_in` at edge k+2. `ppo` stays 0 in this mode.
- R9: Pulling `rst_n` low while `err_n` is low sets `err_n` to 1 at once, without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cascade_en | input | 1 | 0: single instance; 1: part of a two-instance chain |
| stage_b | input | 1 | In a chain: 0 for the first instance, 1 for the second |
| sel_a_n | input | 1 | Word qualifier, active low |
| sel_b_n | input | 1 | Word qualifier, active low |
| d_in | input | DW | Data word |
| par_in | input | 1 | Late parity bit, or the upstream partial parity in the second instance |
| ppo | output | 1 | Registered partial parity toward the second instance |
| err_n | output | 1 | Parity error flag, active low, held for HOLD cycles |

## Verification
Runs of correct parity in every mode show that the one-cycle and two-cycle alignments are right. With a wrong alignment, each run would report errors. Single flipped parity bits measure the exact drop edge and the length of the hold. Mismatches on adjacent edges, and on edges two apart, separate a restarting hold from one that only runs out. Words taken with both selects high and bad parity show that gating suppresses the check. A reset pulse in the middle of a hold, followed by a bad first parity bit, shows that all stale state is cleared.

// File: rtl/parity_pipe_chk.sv
module parity_pipe_chk #(
  parameter int DW   = 14,
  parameter int HOLD = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cascade_en,
  input  logic          stage_b,
  input  logic          sel_a_n,
  input  logic          sel_b_n,
  input  logic [DW-1:0] d_in,
  input  logic          par_in,
  output logic          ppo,
  output logic          err_n
);
  localparam int CW = $clog2(HOLD + 1);

  logic [DW-1:0] word_q;
  logic          word_vld;
  logic          dpar_d1;
  logic          vld_d1;
  logic [CW-1:0] hold_cnt;

  logic accept, in_second, part_sum, mismatch;

  assign accept    = !(sel_a_n && sel_b_n);
  assign in_second = cascade_en && stage_b;
  assign part_sum  = (^word_q) ^ par_in;
  assign mismatch  = in_second ? (vld_d1 && (dpar_d1 ^ par_in))
                               : (!cascade_en && word_vld && part_sum);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q   <= '0;
      word_vld <= 1'b0;
    end else begin
      if (accept) word_q <= d_in;
      word_vld <= accept;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dpar_d1 <= 1'b0;
      vld_d1  <= 1'b0;
      ppo     <= 1'b0;
    end else begin
      dpar_d1 <= ^word_q;
      vld_d1  <= word_vld;
      ppo     <= !in_second && word_vld && part_sum;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      hold_cnt <= '0;
    else if (mismatch)
      hold_cnt <= CW'(HOLD);
    else if (hold_cnt != '0)
      hold_cnt <= hold_cnt - CW'(1);
  end

  assign err_n = (hold_cnt == '0);
endmodule

// File: rtl/parity_pipe_chk_sva.sv
module parity_pipe_chk_sva (
  input logic clk,
  input logic rst_n,
  input logic cascade_en,
  input logic stage_b,
  input logic sel_a_n,
  input logic sel_b_n,
  input logic ppo,
  input logic err_n
);
  p_release_clean_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (err_n && !ppo));

  p_hold_min_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(err_n) |=> !err_n);

  p_gated_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(err_n) && !cascade_en && $past(!cascade_en, 2)) |-> !$past(sel_a_n && sel_b_n, 2));

  p_first_no_err_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cascade_en && !stage_b) |-> err_n);

  p_second_ppo_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cascade_en && stage_b) |-> !ppo);
endmodule

bind parity_pipe_chk parity_pipe_chk_sva u_sva (
  .clk(clk), .rst_n(rst_n), .cascade_en(cascade_en), .stage_b(stage_b),
  .sel_a_n(sel_a_n), .sel_b_n(sel_b_n), .ppo(ppo), .err_n(err_n)
);

// File: tb/tb_parity_pipe_chk.sv
module tb_parity_pipe_chk;
  localparam int DW = 14;
  localparam int HOLD = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cascade_en = 1'b0, stage_b = 1'b0;
  logic sel_a_n = 1'b1, sel_b_n = 1'b1;
  logic [DW-1:0] d_in = '0;
  logic par_in = 1'b0;
  logic ppo, err_n;

  int checks = 0, fails = 0;
  bit finished = 0;
  int mode = 0;
  int hold = 0;
  logic [DW-1:0] hw[$];
  bit hv[$];

  always #10 clk = ~clk;

  parity_pipe_chk #(.DW(DW), .HOLD(HOLD)) dut (
    .clk(clk), .rst_n(rst_n), .cascade_en(cascade_en), .stage_b(stage_b),
    .sel_a_n(sel_a_n), .sel_b_n(sel_b_n), .d_in(d_in), .par_in(par_in),
    .ppo(ppo), .err_n(err_n)
  );

  function automatic logic [DW-1:0] wrd(input int i);
    return DW'(i * 613 + 91) ^ DW'(i << 3);
  endfunction

  task automatic chk(input logic act, input logic exp, input string req);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic clear_model();
    hold = 0;
    hw = '{'0, '0};
    hv = '{0, 0};
  endtask

  task automatic do_reset(input int m);
    @(negedge clk);
    rst_n = 1'b0;
    mode = m;
    cascade_en = (m != 0);
    stage_b = (m == 2);
    clear_model();
    #1;
    chk(err_n, 1'b1, "R1 err_n in reset");
    chk(ppo, 1'b0, "R1 ppo in reset");
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic step(input logic [DW-1:0] d, input logic p, input logic sa,
                      input logic sb, input string req);
    logic mm, eppo;
    d_in = d; par_in = p; sel_a_n = sa; sel_b_n = sb;
    @(posedge clk);
    mm = 1'b0; eppo = 1'b0;
    if (mode != 2) eppo = hv[0] && ((^hw[0]) ^ p);
    if (mode == 0) mm = eppo;
    if (mode == 2) mm = hv[1] && ((^hw[1]) ^ p);
    if (mm) hold = HOLD;
    else if (hold > 0) hold--;
    hw.push_front(d); hv.push_front(!(sa && sb));
    void'(hw.pop_back()); void'(hv.pop_back());
    @(negedge clk);
    chk(err_n, (hold == 0), req);
    chk(ppo, eppo, req);
  endtask

  // bad/gate are bit masks over step index
  task automatic run_seq(input int base, input int n, input int bad, input int gate,
                         input string req);
    for (int i = 0; i < n; i++) begin
      int lag;
      logic p, sa, sb;
      lag = (mode == 2) ? 2 : 1;
      p = (i >= lag) ? ^wrd(base + i - lag) : 1'b0;
      if (bad[i]) p = ~p;
      if (gate[i]) begin sa = 1'b1; sb = 1'b1; end
      else begin sa = (i % 3 == 1); sb = (i % 3 == 2); end
      step(wrd(base + i), p, sa, sb, req);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      fails++; checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    clear_model();
    do_reset(0);
    run_seq(0, 12, 0, 0, "R2 single clean");
    run_seq(20, 10, 32'h20, 0, "R3 R4 single error");
    run_seq(40, 12, 32'h60, 0, "R5 adjacent errors");
    run_seq(60, 12, 32'h0A0, 0, "R5 errors two apart");
    run_seq(80, 12, 32'h3F0, 32'h1F8, "R6 gated bad parity");
    run_seq(100, 8, 32'h40, 0, "R3 error before reset");
    @(negedge clk);
    rst_n = 1'b0;
    #2;
    chk(err_n, 1'b1, "R9 reset during hold");
    chk(ppo, 1'b0, "R9 ppo in reset");
    clear_model();
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    step(wrd(7), 1'b1, 1'b0, 1'b0, "R1 no stale check");
    step(wrd(8), ~(^wrd(7)), 1'b0, 1'b0, "R2 first valid bad");
    run_seq(120, 6, 0, 0, "R4 recovery");

    do_reset(1);
    run_seq(140, 14, 32'h1234, 32'h0C00, "R7 first instance");

    do_reset(2);
    run_seq(160, 10, 0, 0, "R8 second clean");
    run_seq(180, 12, 32'h110, 32'h400, "R8 second errors");

    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule